// File: doc/BRIEF.md
# INTx and MSI Interrupt Aggregator

This block merges two kinds of interrupt source of a PCIe root port into one interrupt line. Four legacy INTx level inputs are turned into sticky status bits: a rising edge on an input sets its bit, and software clears it by writing a one. Incoming MSI write events, each a 64-bit address with 32-bit data, are checked against a programmed address window. Events that hit the window are queued in a FIFO that software drains through read registers.

The status register also carries a summary bit that is high while the MSI FIFO holds entries. The single interrupt output is the OR of every status bit whose enable bit is set. Software services the line by reading the status register, clearing the INTx bits it has handled, and popping MSI entries while the not-empty flag stays high. For each entry it reads the data word, then the low address word, then the high address word. Reading the high address word pops the entry.

All registers sit in one 12-bit byte-address space and are accessed with single-cycle requests. Read data appears on `reg_rdata_o` in the cycle after the request.

Top module: `irq_agg`

## Requirements
- R1: A rising edge on `intx_i[i]` sets status bit 5+i of the status register (0xB1C) in the next cycle. The bit stays set until software clears it, and a level that stays high does not set it again after a clear.
- R2: Writing the status register clears each INTx status bit where the write data has a one and leaves the bits where it has a zero. When a rising edge and a clear reach the same bit in the same cycle, the bit ends up set.
- R3: `irq_o` is high exactly when some status bit (8..5 INTx, 3 MSI summary) is set together with the same bit of the enable register (0xB0C).
- R4: Status bit 3 reads 1 while the MSI FIFO is non-empty and 0 otherwise. Writing the status register has no effect on it.
- R5: An MSI event is queued only when bit 0 of the capture-control register (0x14) is 1 and the address lies in [base, base+size). Here base is {0x08 high word, 0x04 low word} and size is register 0x0C.
- R6: Entries leave the FIFO in arrival order. Register 0x20 returns the head data, 0x24 the head address bits 31..0, and 0x28 the head address bits 63..32. A read of 0x28 removes the head entry.
- R7: Register 0x1C returns the number of queued entries, and bit 0 of register 0x18 reads 1 while that number is non-zero.
- R8: The FIFO holds FIFO_DEPTH (16) entries. An event that hits the window while the FIFO is full is dropped and sets bit 1 of register 0x18. That bit stays set until software writes a one to bit 1 of 0x18.
- R9: A read of 0x28 while the FIFO is empty returns 0 and leaves the entry count at 0.
- R10: The enable register keeps only bits 8..5 and 3. Every other bit reads back as 0.
- R11: After reset, every register, `irq_o` and `reg_rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request, one cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| intx_i | input | 4 | Legacy INTA..INTD levels, synchronous to clk_i |
| msi_valid_i | input | 1 | MSI write event strobe |
| msi_addr_i | input | 64 | MSI write address |
| msi_data_i | input | 32 | MSI write data |
| irq_o | output | 1 | Combined interrupt output |

## Verification
On every cycle, the assertions check the edge-to-status path and the hold of INTx bits until cleared. They also check that `irq_o` always has an enabled set source, that the entry count never passes the depth, that disabled capture never grows the queue, that the overflow flag stays sticky, and that an empty pop returns zero. Some behaviours can only be shown by the bench's scenarios: the window limits one byte below the base and at base+size, arrival ordering across a full FIFO, dropping the seventeenth event, the same-cycle set-over-clear case and the read-back masks of the registers.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_AW   = 12;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned MSI_AW   = 64;
  localparam int unsigned MSI_DW   = 32;
  localparam int unsigned NUM_INTX = 4;
  localparam int unsigned INTX_LSB = 5;
  localparam int unsigned SUM_BIT  = 3;

  localparam logic [REG_AW-1:0] A_BASE_LO = 12'h004;
  localparam logic [REG_AW-1:0] A_BASE_HI = 12'h008;
  localparam logic [REG_AW-1:0] A_WIN_SZ  = 12'h00C;
  localparam logic [REG_AW-1:0] A_CAP_EN  = 12'h014;
  localparam logic [REG_AW-1:0] A_Q_STAT  = 12'h018;
  localparam logic [REG_AW-1:0] A_Q_OCC   = 12'h01C;
  localparam logic [REG_AW-1:0] A_Q_DATA  = 12'h020;
  localparam logic [REG_AW-1:0] A_Q_ALO   = 12'h024;
  localparam logic [REG_AW-1:0] A_Q_AHI   = 12'h028;
  localparam logic [REG_AW-1:0] A_IRQ_EN  = 12'hB0C;
  localparam logic [REG_AW-1:0] A_IRQ_ST  = 12'hB1C;

  localparam logic [REG_DW-1:0] EN_MASK = 32'h0000_01E8;

  typedef struct packed {
    logic [MSI_AW-1:0] addr;
    logic [MSI_DW-1:0] data;
  } msi_entry_t;
endpackage

// File: rtl/irq_agg_intx.sv
module irq_agg_intx #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] lvl_q;
  logic [N-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic rise;
    assign rise = lvl_i[i] & ~lvl_q[i];
    // a new edge beats a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_q[i] <= 1'b0;
      else if (rise)     stat_q[i] <= 1'b1;
      else if (clr_i[i]) stat_q[i] <= 1'b0;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_agg_win.sv
module irq_agg_win #(
  parameter int unsigned AW = 64,
  parameter int unsigned SW = 32
) (
  input  logic          valid_i,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] size_i,
  output logic          hit_o
);
  logic [AW-1:0] off;
  assign off   = addr_i - base_i;
  assign hit_o = valid_i & en_i & (addr_i >= base_i) & (off < AW'(size_i));
endmodule

// File: rtl/irq_agg_fifo.sv
module irq_agg_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 96,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= step(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic [NUM_INTX-1:0] intx_i,
  input  logic              msi_valid_i,
  input  logic [MSI_AW-1:0] msi_addr_i,
  input  logic [MSI_DW-1:0] msi_data_i,
  output logic              irq_o
);
  localparam int unsigned ENT_W = $bits(msi_entry_t);

  logic              wr, rd;
  logic [REG_DW-1:0] int_en, base_lo, base_hi, win_size;
  logic              cap_en, msi_ovf;
  logic [NUM_INTX-1:0] intx_clr, intx_stat;
  logic              hit, fifo_full, fifo_empty, pop;
  logic [CNT_W-1:0]  fifo_cnt;
  msi_entry_t        head, in_ent;
  logic [ENT_W-1:0]  head_raw;
  logic [REG_DW-1:0] stat_vec, rd_mux;

  assign wr = reg_req_i & reg_we_i;
  assign rd = reg_req_i & ~reg_we_i;

  assign intx_clr = (wr && reg_addr_i == A_IRQ_ST)
                  ? reg_wdata_i[INTX_LSB +: NUM_INTX] : '0;

  irq_agg_intx #(.N(NUM_INTX)) u_intx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (intx_i),
    .clr_i  (intx_clr),
    .stat_o (intx_stat)
  );

  irq_agg_win #(.AW(MSI_AW), .SW(REG_DW)) u_win (
    .valid_i (msi_valid_i),
    .en_i    (cap_en),
    .addr_i  (msi_addr_i),
    .base_i  ({base_hi, base_lo}),
    .size_i  (win_size),
    .hit_o   (hit)
  );

  assign in_ent.addr = msi_addr_i;
  assign in_ent.data = msi_data_i;
  assign pop = rd && (reg_addr_i == A_Q_AHI) && !fifo_empty;

  irq_agg_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (hit),
    .wdata_i (in_ent),
    .pop_i   (pop),
    .rdata_o (head_raw),
    .cnt_o   (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );
  assign head = msi_entry_t'(head_raw);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en   <= '0;
      base_lo  <= '0;
      base_hi  <= '0;
      win_size <= '0;
      cap_en   <= 1'b0;
      msi_ovf  <= 1'b0;
    end else begin
      if (wr) begin
        case (reg_addr_i)
          A_IRQ_EN:  int_en   <= reg_wdata_i & EN_MASK;
          A_BASE_LO: base_lo  <= reg_wdata_i;
          A_BASE_HI: base_hi  <= reg_wdata_i;
          A_WIN_SZ:  win_size <= reg_wdata_i;
          A_CAP_EN:  cap_en   <= reg_wdata_i[0];
          default: ;
        endcase
      end
      // sticky drop flag: set wins over clear
      if (hit && fifo_full)                                  msi_ovf <= 1'b1;
      else if (wr && reg_addr_i == A_Q_STAT && reg_wdata_i[1]) msi_ovf <= 1'b0;
    end
  end

  always_comb begin
    stat_vec = '0;
    stat_vec[INTX_LSB +: NUM_INTX] = intx_stat;
    stat_vec[SUM_BIT] = ~fifo_empty;
  end

  assign irq_o = |(stat_vec & int_en);

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      A_IRQ_EN:  rd_mux = int_en;
      A_IRQ_ST:  rd_mux = stat_vec;
      A_BASE_LO: rd_mux = base_lo;
      A_BASE_HI: rd_mux = base_hi;
      A_WIN_SZ:  rd_mux = win_size;
      A_CAP_EN:  rd_mux = {31'b0, cap_en};
      A_Q_STAT:  rd_mux = {30'b0, msi_ovf, ~fifo_empty};
      A_Q_OCC:   rd_mux = REG_DW'(fifo_cnt);
      A_Q_DATA:  rd_mux = fifo_empty ? '0 : head.data;
      A_Q_ALO:   rd_mux = fifo_empty ? '0 : head.addr[31:0];
      A_Q_AHI:   rd_mux = fifo_empty ? '0 : head.addr[63:32];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  reg_rdata_o <= '0;
    else if (rd)  reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       intx_i,
  input logic             msi_valid_i,
  input logic             reg_req_i,
  input logic             reg_we_i,
  input logic [11:0]      reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic [31:0]      reg_rdata_o,
  input logic             irq_o,
  input logic [3:0]       stat_i,
  input logic [31:0]      en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cap_en_i,
  input logic             ovf_i
);
  logic st_wr, qs_clr, pop_rd;
  assign st_wr  = reg_req_i && reg_we_i && reg_addr_i == 12'hB1C;
  assign qs_clr = reg_req_i && reg_we_i && reg_addr_i == 12'h018 && reg_wdata_i[1];
  assign pop_rd = reg_req_i && !reg_we_i && reg_addr_i == 12'h028;

  for (genvar i = 0; i < 4; i++) begin : g_intx
    p_edge_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(intx_i[i]) |=> stat_i[i]);
    p_hold_until_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_i[i] && !(st_wr && reg_wdata_i[5+i])) |=> stat_i[i]);
  end

  p_irq_has_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|(stat_i & en_i[8:5])) || (en_i[3] && cnt_i != '0)));

  p_no_capture_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_valid_i && !cap_en_i) |=> (cnt_i <= $past(cnt_i)));

  p_occ_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !qs_clr) |=> ovf_i);

  p_empty_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_rd && cnt_i == '0 && !msi_valid_i) |=> (reg_rdata_o == '0 && cnt_i == '0));
endmodule

bind irq_agg irq_agg_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .intx_i      (intx_i),
  .msi_valid_i (msi_valid_i),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .stat_i      (intx_stat),
  .en_i        (int_en),
  .cnt_i       (fifo_cnt),
  .cap_en_i    (cap_en),
  .ovf_i       (msi_ovf)
);

// File: tb/tb_irq_agg.sv
module tb_irq_agg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [3:0]  intx_i = '0;
  logic        msi_valid_i = 1'b0;
  logic [63:0] msi_addr_i = '0;
  logic [31:0] msi_data_i = '0;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;

  always #2 clk_i = ~clk_i;  // 250 MHz

  irq_agg dut (.*);

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
    @(negedge clk_i);
    reg_req_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic msi(logic [63:0] a, logic [31:0] d);
    @(negedge clk_i);
    msi_valid_i = 1'b1; msi_addr_i = a; msi_data_i = d;
    @(negedge clk_i);
    msi_valid_i = 1'b0;
  endtask

  task automatic drive_intx(logic [3:0] v);
    @(negedge clk_i);
    intx_i = v;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R11", "irq after reset", irq_o, 0);
    check("R11", "rdata after reset", reg_rdata_o, 0);
    rd(12'hB1C, d); check("R11", "status", d, 0);
    rd(12'hB0C, d); check("R11", "enable", d, 0);
    rd(12'h01C, d); check("R11", "occupancy", d, 0);
    rd(12'h014, d); check("R11", "capture enable", d, 0);
  endtask

  task automatic t_enable_mask;
    logic [31:0] d;
    wr(12'hB0C, 32'hFFFF_FFFF);
    rd(12'hB0C, d); check("R10", "enable readback", d, 32'h1E8);
    wr(12'hB0C, 32'h0);
  endtask

  task automatic t_intx;
    logic [31:0] d;
    drive_intx(4'b0010);
    rd(12'hB1C, d); check("R1", "INTB sets bit6", d, 32'h040);
    check("R3", "irq masked", irq_o, 0);
    wr(12'hB0C, 32'h040);
    check("R3", "irq enabled", irq_o, 1);
    wr(12'hB1C, 32'h0);
    rd(12'hB1C, d); check("R2", "zero write keeps", d, 32'h040);
    wr(12'hB1C, 32'h040);
    rd(12'hB1C, d); check("R1", "held level no re-set", d, 32'h0);
    check("R3", "irq after clear", irq_o, 0);
    drive_intx(4'b1001);
    rd(12'hB1C, d); check("R1", "INTA+INTD", d, 32'h120);
    check("R3", "other bit enabled only", irq_o, 0);
    wr(12'hB0C, 32'h020);
    check("R3", "INTA enabled", irq_o, 1);
    wr(12'hB1C, 32'h100);
    rd(12'hB1C, d); check("R2", "partial clear", d, 32'h020);
    wr(12'hB1C, 32'h1E0);
    // set and clear of bit7 in the same cycle
    @(negedge clk_i);
    intx_i = 4'b1101;
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 12'hB1C; reg_wdata_i = 32'h080;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
    rd(12'hB1C, d); check("R2", "set wins over clear", d, 32'h080);
    wr(12'hB1C, 32'h1E0);
    wr(12'hB0C, 32'h0);
    drive_intx(4'b0000);
  endtask

  task automatic t_msi_window;
    logic [31:0] d;
    wr(12'h004, BASE[31:0]);
    wr(12'h008, BASE[63:32]);
    wr(12'h00C, 32'd4096);
    msi(BASE, 32'h11);
    rd(12'h01C, d); check("R5", "capture disabled", d, 0);
    wr(12'h014, 32'h1);
    msi(BASE - 1, 32'h22);
    rd(12'h01C, d); check("R5", "below base", d, 0);
    msi(BASE + 4096, 32'h33);
    rd(12'h01C, d); check("R5", "at base+size", d, 0);
    msi(64'h0000_0000_0000_1000, 32'h44);
    rd(12'h01C, d); check("R5", "wrong high word", d, 0);
    msi(BASE, 32'h55);
    msi(BASE + 4095, 32'h66);
    rd(12'h01C, d); check("R7", "occupancy 2", d, 2);
    rd(12'h018, d); check("R7", "not-empty flag", d, 1);
    rd(12'hB1C, d); check("R4", "summary bit", d, 32'h008);
    wr(12'hB1C, 32'h008);
    rd(12'hB1C, d); check("R4", "summary ignores write", d, 32'h008);
    wr(12'hB0C, 32'h008);
    check("R3", "irq from summary", irq_o, 1);
    rd(12'h020, d); check("R6", "data 1", d, 32'h55);
    rd(12'h024, d); check("R6", "addr lo 1", d, 32'h0000_1000);
    rd(12'h01C, d); check("R6", "no pop before hi", d, 2);
    rd(12'h028, d); check("R6", "addr hi 1", d, 32'h1);
    rd(12'h01C, d); check("R6", "popped", d, 1);
    rd(12'h020, d); check("R6", "data 2", d, 32'h66);
    rd(12'h024, d); check("R6", "addr lo 2", d, 32'h0000_1FFF);
    rd(12'h028, d); check("R6", "addr hi 2", d, 32'h1);
    rd(12'hB1C, d); check("R4", "summary cleared", d, 0);
    check("R3", "irq drops when empty", irq_o, 0);
    rd(12'h028, d); check("R9", "empty pop data", d, 0);
    rd(12'h01C, d); check("R9", "empty pop occ", d, 0);
    wr(12'hB0C, 32'h0);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    for (int i = 0; i < 17; i++) msi(BASE + 64'(4 * i), 32'hA0 + 32'(i));
    rd(12'h01C, d); check("R8", "full occupancy", d, 16);
    rd(12'h018, d); check("R8", "overflow+nonempty", d, 32'h3);
    for (int i = 0; i < 16; i++) begin
      rd(12'h020, d); check("R6", "fifo order data", d, 32'hA0 + 32'(i));
      rd(12'h024, d); check("R6", "fifo order addr", d, 32'h1000 + 32'(4 * i));
      rd(12'h028, d);
    end
    rd(12'h018, d); check("R8", "overflow sticky", d, 32'h2);
    wr(12'h018, 32'h1);
    rd(12'h018, d); check("R8", "bit0 write ignored", d, 32'h2);
    wr(12'h018, 32'h2);
    rd(12'h018, d); check("R8", "overflow cleared", d, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_enable_mask();
    t_intx();
    t_msi_window();
    t_overflow();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule